// File: doc/BRIEF.md
# Host Port Register Front End

This block holds the registers through which an external host processor and the local CPU coordinate access to the local memory space. It has two independent register ports, one for the host and one for the CPU. Each port has its own permissions over the same four registers: a power and emulation management word, a control word with interrupt handshake bits, and a pair of 32-bit memory pointers. One pointer is for host reads and the other is for host writes. A control bit either ties the two pointers together or lets them move separately.

Interrupts pass in both directions through write-one-to-act bits in the control word. The CPU raises the host interrupt and the host clears it. The host raises the CPU interrupt and the CPU acknowledges it. The host side can run as a 16-bit port, in which case every host access moves one halfword selected by a lane input, or as a 32-bit port. The choice is taken from a static input once, just after reset. The two pointer values are driven out to the memory-side logic. Read data on both ports is registered.

Top module: `hpi_regs`

## Requirements
- R1: While reset is asserted, both interrupt outputs, both pointer outputs and both read-data outputs are zero, and every register returns to zero.
- R2: `wide_cfg_i` is sampled at the first rising clock edge after reset is released, and later changes are ignored. A sampled 1 selects 32-bit host access. A sampled 0 selects 16-bit host access. In 16-bit mode, `host_hi_i`=1 addresses bits 31:16 and `host_hi_i`=0 addresses bits 15:0. A host write changes only that half. A host read returns that half in bits 15:0, with the upper bits zero.
- R3: Byte offsets are decoded as follows: 0x00 is the management word, 0x30 is control, 0x34 is the write pointer and 0x38 is the read pointer. Any other offset on either port reads as zero, and writes to it change nothing.
- R4: The CPU can read and write the management word. A host write to it changes nothing, and a host read of it returns zero.
- R5: The host can read and write both pointers. The CPU can read them, but CPU writes to them are ignored.
- R6: The control word has bit 2 as the host-interrupt bit. A CPU write with bit 2 = 1 sets `host_irq_o`. A host write with bit 2 = 1 clears it. A 0 in bit 2 from either side has no effect.
- R7: The control word has bit 1 as the CPU-interrupt bit. A host write with bit 1 = 1 sets `cpu_irq_o`. A CPU write with bit 1 = 1 clears it. A 0 in bit 1 from either side has no effect.
- R8: Control bit 0 selects the pointer mode: 1 means tied and 0 means separate. The bit resets to 0 and only a host write changes it. In tied mode, a host write to either pointer stores the same merged value into both pointers. In separate mode, a host write changes only the addressed pointer.
- R9: Control bit 3, the ready flag, and control bits 31:4 always read as zero.
- R10: If the host and the CPU both write the control word in the same cycle, the host write takes effect and the CPU write is dropped.
- R11: Read data on each port appears on the cycle after the read request and shows the register state from before that edge. It holds its value until the next read on the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_cfg_i | input | 1 | Host width strap, 1 = 32-bit |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | ADDR_W | Host byte offset |
| host_hi_i | input | 1 | Upper halfword select in 16-bit mode |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, registered |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write enable |
| cpu_addr_i | input | ADDR_W | CPU byte offset |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_rdata_o | output | DATA_W | CPU read data, registered |
| host_irq_o | output | 1 | Interrupt toward the host |
| cpu_irq_o | output | 1 | Interrupt toward the CPU |
| wr_ptr_o | output | DATA_W | Host write pointer |
| rd_ptr_o | output | DATA_W | Host read pointer |

## Verification
The properties assume that request, write-enable, address and data inputs are known from reset onward, and that a write request carries its data in the same cycle. They also assume offsets are compared as whole byte addresses, so a misaligned offset counts as reserved. The stimulus drives every input to a defined value from time zero and changes inputs only on falling edges. Offsets are drawn from the four mapped words, with the rest picked at random from the reserved space. Host and CPU control writes are made to collide on purpose, so both the priority path and the tied-pointer path stay inside these assumptions.

// File: rtl/hpi_regs_pkg.sv
package hpi_regs_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PM,
    SEL_CTRL,
    SEL_WPTR,
    SEL_RPTR
  } reg_sel_e;

  localparam int unsigned OFF_PM   = 32'h00;
  localparam int unsigned OFF_CTRL = 32'h30;
  localparam int unsigned OFF_WPTR = 32'h34;
  localparam int unsigned OFF_RPTR = 32'h38;

  localparam int CTL_MODE = 0;
  localparam int CTL_CIRQ = 1;
  localparam int CTL_HIRQ = 2;
  localparam int CTL_RDY  = 3;
endpackage

// File: rtl/hpi_decode.sv
module hpi_decode
  import hpi_regs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFF_PM))   sel_o = SEL_PM;
    if (addr_i == ADDR_W'(OFF_CTRL)) sel_o = SEL_CTRL;
    if (addr_i == ADDR_W'(OFF_WPTR)) sel_o = SEL_WPTR;
    if (addr_i == ADDR_W'(OFF_RPTR)) sel_o = SEL_RPTR;
  end
endmodule

// File: rtl/hpi_irq.sv
module hpi_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic h_ctl_wr_i,
  input  logic h_cirq_bit_i,
  input  logic h_hirq_bit_i,
  input  logic c_ctl_wr_i,
  input  logic c_cirq_bit_i,
  input  logic c_hirq_bit_i,
  output logic host_irq_o,
  output logic cpu_irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_irq_o <= 1'b0;
      cpu_irq_o  <= 1'b0;
    end else if (h_ctl_wr_i) begin
      // host owns the cycle; a colliding CPU write is dropped
      if (h_cirq_bit_i) cpu_irq_o  <= 1'b1;
      if (h_hirq_bit_i) host_irq_o <= 1'b0;
    end else if (c_ctl_wr_i) begin
      if (c_hirq_bit_i) host_irq_o <= 1'b1;
      if (c_cirq_bit_i) cpu_irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/hpi_ptr_pair.sv
module hpi_ptr_pair #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tied_i,
  input  logic              wide_i,
  input  logic              hi_i,
  input  logic              wr_w_i,
  input  logic              wr_r_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] wptr_o,
  output logic [DATA_W-1:0] rptr_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic wide, input logic hi);
    if (wide) return new_v;
    if (hi)   return {new_v[HALF_W-1:0], old_v[HALF_W-1:0]};
    return {old_v[DATA_W-1:HALF_W], new_v[HALF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] w_next, r_next, tied_next;

  always_comb begin
    w_next    = merge(wptr_o, wdata_i, wide_i, hi_i);
    r_next    = merge(rptr_o, wdata_i, wide_i, hi_i);
    tied_next = wr_w_i ? w_next : r_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o <= '0;
      rptr_o <= '0;
    end else if (tied_i && (wr_w_i || wr_r_i)) begin
      wptr_o <= tied_next;
      rptr_o <= tied_next;
    end else begin
      if (wr_w_i) wptr_o <= w_next;
      if (wr_r_i) rptr_o <= r_next;
    end
  end
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
  import hpi_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_cfg_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_hi_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              host_irq_o,
  output logic              cpu_irq_o,
  output logic [DATA_W-1:0] wr_ptr_o,
  output logic [DATA_W-1:0] rd_ptr_o
);
  localparam int HALF_W = DATA_W / 2;

  reg_sel_e h_sel, c_sel;
  logic wide_q, armed_q, wide;
  logic tied_q;
  logic [DATA_W-1:0] pm_q, ctrl_word, h_full, h_rd, c_rd;
  logic h_wr, h_rdq, c_wr, c_rdq, h_lane_ok, h_ctl_wr, c_ctl_wr;

  hpi_decode #(.ADDR_W(ADDR_W)) i_h_dec (.addr_i(host_addr_i), .sel_o(h_sel));
  hpi_decode #(.ADDR_W(ADDR_W)) i_c_dec (.addr_i(cpu_addr_i),  .sel_o(c_sel));

  // width strap latched once on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      wide_q  <= wide_cfg_i;
      armed_q <= 1'b1;
    end
  end
  assign wide = armed_q ? wide_q : wide_cfg_i;

  assign h_wr      = host_req_i & host_we_i;
  assign h_rdq     = host_req_i & ~host_we_i;
  assign c_wr      = cpu_req_i & cpu_we_i;
  assign c_rdq     = cpu_req_i & ~cpu_we_i;
  assign h_lane_ok = wide | ~host_hi_i;
  assign h_ctl_wr  = h_wr & h_lane_ok & (h_sel == SEL_CTRL);
  assign c_ctl_wr  = c_wr & (c_sel == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tied_q <= 1'b0;
      pm_q   <= '0;
    end else begin
      if (h_ctl_wr) tied_q <= host_wdata_i[CTL_MODE];
      if (c_wr && c_sel == SEL_PM) pm_q <= cpu_wdata_i;
    end
  end

  hpi_irq i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_ctl_wr_i  (h_ctl_wr),
    .h_cirq_bit_i(host_wdata_i[CTL_CIRQ]),
    .h_hirq_bit_i(host_wdata_i[CTL_HIRQ]),
    .c_ctl_wr_i  (c_ctl_wr),
    .c_cirq_bit_i(cpu_wdata_i[CTL_CIRQ]),
    .c_hirq_bit_i(cpu_wdata_i[CTL_HIRQ]),
    .host_irq_o  (host_irq_o),
    .cpu_irq_o   (cpu_irq_o)
  );

  hpi_ptr_pair #(.DATA_W(DATA_W)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tied_i (tied_q),
    .wide_i (wide),
    .hi_i   (host_hi_i),
    .wr_w_i (h_wr && h_sel == SEL_WPTR),
    .wr_r_i (h_wr && h_sel == SEL_RPTR),
    .wdata_i(host_wdata_i),
    .wptr_o (wr_ptr_o),
    .rptr_o (rd_ptr_o)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CTL_MODE] = tied_q;
    ctrl_word[CTL_CIRQ] = cpu_irq_o;
    ctrl_word[CTL_HIRQ] = host_irq_o;
    ctrl_word[CTL_RDY]  = 1'b0;
  end

  always_comb begin
    case (h_sel)
      SEL_CTRL: h_full = ctrl_word;
      SEL_WPTR: h_full = wr_ptr_o;
      SEL_RPTR: h_full = rd_ptr_o;
      default:  h_full = '0;  // management word hidden from host
    endcase
    if (wide)           h_rd = h_full;
    else if (host_hi_i) h_rd = {{HALF_W{1'b0}}, h_full[DATA_W-1:HALF_W]};
    else                h_rd = {{HALF_W{1'b0}}, h_full[HALF_W-1:0]};
    case (c_sel)
      SEL_PM:   c_rd = pm_q;
      SEL_CTRL: c_rd = ctrl_word;
      SEL_WPTR: c_rd = wr_ptr_o;
      SEL_RPTR: c_rd = rd_ptr_o;
      default:  c_rd = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o <= '0;
      cpu_rdata_o  <= '0;
    end else begin
      if (h_rdq) host_rdata_o <= h_rd;
      if (c_rdq) cpu_rdata_o  <= c_rd;
    end
  end
endmodule

// File: rtl/hpi_regs_chk.sv
module hpi_regs_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_req_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              h_b1_i,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              c_b1_i,
  input logic              c_b2_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_irq_o,
  input logic              cpu_irq_o,
  input logic [DATA_W-1:0] wr_ptr_o,
  input logic [DATA_W-1:0] rd_ptr_o
);
  logic h_any_ctl, c_ctl, h_ptr_wr, h_rd_pm, h_rd_rsvd;

  assign h_any_ctl = host_req_i && host_we_i && host_addr_i == ADDR_W'(8'h30);
  assign c_ctl     = cpu_req_i && cpu_we_i && cpu_addr_i == ADDR_W'(8'h30);
  assign h_ptr_wr  = host_req_i && host_we_i &&
                     (host_addr_i == ADDR_W'(8'h34) || host_addr_i == ADDR_W'(8'h38));
  assign h_rd_pm   = host_req_i && !host_we_i && host_addr_i == '0;
  assign h_rd_rsvd = host_req_i && !host_we_i && host_addr_i != '0 &&
                     host_addr_i != ADDR_W'(8'h30) && host_addr_i != ADDR_W'(8'h34) &&
                     host_addr_i != ADDR_W'(8'h38);

  p_hirq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_ctl && c_b2_i && !h_any_ctl) |=> host_irq_o);

  p_hirq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_irq_o) |-> $past(c_ctl && c_b2_i));

  p_cirq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_ctl && c_b1_i && !h_any_ctl) |=> !cpu_irq_o);

  p_cirq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_irq_o) |-> $past(h_any_ctl && h_b1_i));

  p_ptr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_ptr_wr |=> ($stable(wr_ptr_o) && $stable(rd_ptr_o)));

  p_pm_hidden_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_rd_pm |=> host_rdata_o == '0);

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_rd_rsvd |=> host_rdata_o == '0);
endmodule

bind hpi_regs hpi_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_req_i  (host_req_i),
  .host_we_i   (host_we_i),
  .host_addr_i (host_addr_i),
  .h_b1_i      (host_wdata_i[1]),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .c_b1_i      (cpu_wdata_i[1]),
  .c_b2_i      (cpu_wdata_i[2]),
  .host_rdata_o(host_rdata_o),
  .host_irq_o  (host_irq_o),
  .cpu_irq_o   (cpu_irq_o),
  .wr_ptr_o    (wr_ptr_o),
  .rd_ptr_o    (rd_ptr_o)
);

// File: tb/test_hpi_regs.sv
module test_hpi_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_cfg = 1'b1;
  logic host_req = 0, host_we = 0, host_hi = 0;
  logic [6:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic cpu_req = 0, cpu_we = 0;
  logic [6:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] host_rdata, cpu_rdata, wr_ptr, rd_ptr;
  logic host_irq, cpu_irq;

  int total = 0, bad = 0, cycles = 0;

  // bench model
  logic [31:0] m_pm, m_wptr, m_rptr, m_hrd, m_crd;
  logic m_hirq, m_cirq, m_tied, m_wide, m_armed;

  always #2 clk = ~clk;

  hpi_regs i_hpi_regs (
    .clk_i(clk), .rst_ni(rst_n), .wide_cfg_i(wide_cfg),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_hi_i(host_hi), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .host_irq_o(host_irq), .cpu_irq_o(cpu_irq),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_ctrl();
    return {28'd0, 1'b0, m_hirq, m_cirq, m_tied};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic hi);
    if (m_wide) return d;
    return hi ? {d[15:0], o[15:0]} : {o[31:16], d[15:0]};
  endfunction

  function automatic logic [31:0] host_rd(input logic [6:0] a, input logic hi);
    logic [31:0] f;
    case (a)
      7'h30: f = m_ctrl();
      7'h34: f = m_wptr;
      7'h38: f = m_rptr;
      default: f = '0;
    endcase
    if (m_wide) return f;
    return hi ? {16'd0, f[31:16]} : {16'd0, f[15:0]};
  endfunction

  function automatic logic [31:0] cpu_rd(input logic [6:0] a);
    case (a)
      7'h00: return m_pm;
      7'h30: return m_ctrl();
      7'h34: return m_wptr;
      7'h38: return m_rptr;
      default: return '0;
    endcase
  endfunction

  task automatic model_step(input logic hr, hw, input logic [6:0] ha, input logic hh,
                            input logic [31:0] hd, input logic cr, cw,
                            input logic [6:0] ca, input logic [31:0] cd);
    logic hctl;
    logic [31:0] nv;
    if (!m_armed) begin m_wide = wide_cfg; m_armed = 1'b1; end
    if (hr && !hw) m_hrd = host_rd(ha, hh);
    if (cr && !cw) m_crd = cpu_rd(ca);
    hctl = hr && hw && ha == 7'h30 && (m_wide || !hh);
    if (hctl) begin
      if (hd[1]) m_cirq = 1'b1;
      if (hd[2]) m_hirq = 1'b0;
      m_tied = hd[0];
    end
    if (hr && hw && (ha == 7'h34 || ha == 7'h38)) begin
      nv = merge(ha == 7'h34 ? m_wptr : m_rptr, hd, hh);
      if (m_tied) begin m_wptr = nv; m_rptr = nv; end
      else if (ha == 7'h34) m_wptr = nv;
      else m_rptr = nv;
    end
    if (cr && cw && ca == 7'h00) m_pm = cd;
    if (cr && cw && ca == 7'h30 && !hctl) begin
      if (cd[2]) m_hirq = 1'b1;
      if (cd[1]) m_cirq = 1'b0;
    end
  endtask

  task automatic check_all(input string tag);
    chk({31'd0, host_irq}, {31'd0, m_hirq}, {tag, " host_irq"});
    chk({31'd0, cpu_irq},  {31'd0, m_cirq}, {tag, " cpu_irq"});
    chk(wr_ptr, m_wptr, {tag, " wr_ptr"});
    chk(rd_ptr, m_rptr, {tag, " rd_ptr"});
    chk(host_rdata, m_hrd, {tag, " host_rdata"});
    chk(cpu_rdata,  m_crd, {tag, " cpu_rdata"});
  endtask

  task automatic cyc(input logic hr, hw, input logic [6:0] ha, input logic hh,
                     input logic [31:0] hd, input logic cr, cw,
                     input logic [6:0] ca, input logic [31:0] cd, input string tag);
    host_req = hr; host_we = hw; host_addr = ha; host_hi = hh; host_wdata = hd;
    cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    @(posedge clk);
    model_step(hr, hw, ha, hh, hd, cr, cw, ca, cd);
    @(negedge clk);
    host_req = 0; cpu_req = 0;
    check_all(tag);
  endtask

  task automatic hw_(input logic [6:0] a, input logic hh, input logic [31:0] d, input string tag);
    cyc(1, 1, a, hh, d, 0, 0, 0, 0, tag);
  endtask
  task automatic hr_(input logic [6:0] a, input logic hh, input string tag);
    cyc(1, 0, a, hh, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic cw_(input logic [6:0] a, input logic [31:0] d, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 1, a, d, tag);
  endtask
  task automatic cr_(input logic [6:0] a, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 0, a, 0, tag);
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 0; wide_cfg = cfg;
    host_req = 0; cpu_req = 0;
    m_pm = '0; m_wptr = '0; m_rptr = '0; m_hrd = '0; m_crd = '0;
    m_hirq = 0; m_cirq = 0; m_tied = 0; m_wide = 0; m_armed = 0;
    repeat (2) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
  endtask

  function automatic logic [6:0] pick_addr();
    case ($urandom % 7)
      0: return 7'h00;
      1, 6: return 7'h30;
      2: return 7'h34;
      3: return 7'h38;
      default: return 7'($urandom);
    endcase
  endfunction

  task automatic rand_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [6:0] ha = pick_addr();
      logic [6:0] ca = pick_addr();
      cyc($urandom % 3 != 0, $urandom % 2 == 0, ha, $urandom % 2 == 0, $urandom,
          $urandom % 3 != 0, $urandom % 2 == 0, ca, $urandom, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, 32-bit host
    do_reset(1'b1);
    cr_(7'h30, "R1 ctrl zero after reset");
    hr_(7'h30, 0, "R9 ctrl read host");
    // R4: management word
    cw_(7'h00, 32'hA5A5_1234, "R4 cpu write pm");
    hw_(7'h00, 0, 32'hFFFF_FFFF, "R4 host write pm ignored");
    cr_(7'h00, "R4 cpu read pm");
    hr_(7'h00, 0, "R4 host read pm zero");
    // R8 separate mode, R5 cpu write ignored
    hw_(7'h34, 0, 32'h1111_0000, "R8 separate wptr");
    hw_(7'h38, 0, 32'h2222_0000, "R8 separate rptr");
    cw_(7'h34, 32'hDEAD_BEEF, "R5 cpu write wptr ignored");
    cw_(7'h38, 32'hDEAD_BEEF, "R5 cpu write rptr ignored");
    cr_(7'h34, "R5 cpu read wptr");
    hr_(7'h38, 0, "R5 host read rptr");
    // R8 tied mode
    hw_(7'h30, 0, 32'h1, "R8 set tied");
    hw_(7'h38, 0, 32'h3333_4444, "R8 tied write both");
    cw_(7'h30, 32'h0, "R8 cpu cannot clear mode");
    hr_(7'h30, 0, "R8 mode still tied");
    hw_(7'h34, 0, 32'h5555_6666, "R8 tied via wptr");
    hw_(7'h30, 0, 32'h0, "R8 back to separate");
    // R6 host interrupt
    cw_(7'h30, 32'h4, "R6 cpu sets host irq");
    cw_(7'h30, 32'h0, "R6 zero no effect");
    hw_(7'h30, 0, 32'h0, "R6 host zero no effect");
    hw_(7'h30, 0, 32'h4, "R6 host clears host irq");
    // R7 cpu interrupt
    hw_(7'h30, 0, 32'h2, "R7 host sets cpu irq");
    cw_(7'h30, 32'h0, "R7 cpu zero no effect");
    cr_(7'h30, "R7 cpu sees pending");
    cw_(7'h30, 32'h2, "R7 cpu clears cpu irq");
    // R9 ready flag
    hw_(7'h30, 0, 32'hFFFF_FFFF, "R9 write all ones");
    hr_(7'h30, 0, "R9 ready reads zero");
    cr_(7'h30, "R9 cpu ready zero");
    // R10 collision: host wins
    cyc(1, 1, 7'h30, 0, 32'h1, 1, 1, 7'h30, 32'h6, "R10 host priority");
    cr_(7'h30, "R10 ctrl after collision");
    // R3 reserved
    hw_(7'h44, 0, 32'hFFFF_FFFF, "R3 reserved write");
    cw_(7'h3C, 32'hFFFF_FFFF, "R3 cpu reserved write");
    hr_(7'h3C, 0, "R3 host reserved read");
    cr_(7'h10, "R3 cpu reserved read");
    // R11 hold
    cw_(7'h00, 32'h0BAD_F00D, "R11 hold after write");
    hw_(7'h34, 0, 32'h7777_8888, "R11 hold host");
    rand_run(3000, "R11 random wide");
    // R2 16-bit host
    do_reset(1'b0);
    hw_(7'h34, 0, 32'hFFFF_BEEF, "R2 low half");
    wide_cfg = 1'b1;
    hw_(7'h34, 1, 32'h1234_CAFE, "R2 high half, strap change ignored");
    hr_(7'h34, 1, "R2 read high half");
    hr_(7'h34, 0, "R2 read low half");
    hw_(7'h30, 1, 32'h0000_0007, "R2 ctrl upper lane no effect");
    hr_(7'h30, 0, "R2 ctrl unchanged");
    rand_run(3000, "R2 random narrow");
    summary();
    $finish;
  end
endmodule